// File: doc/BRIEF.md
# Two-Section Falling-Edge Up Counter

This block is a four-bit up counter built from two sections that can run on their own or be chained. The lower section is one bit wide and divides its clock by two. The upper section is three bits wide and divides its clock by eight. Each section has its own count-clock input and advances on a falling edge of that input. Both count clocks are treated as ordinary data signals. A free-running system clock samples each one through a synchronizer, and a falling edge is found from two successive samples. The old ripple counter is reproduced this way in fully synchronous logic.

A chaining control feeds the lower bit into the upper section, which gives a divide-by-sixteen binary counter. In that mode the upper count input is ignored. Two clear inputs form a gated clear, and the counter clears only when both are high. A modulo-thirteen control feeds a decode of the count back into that clear, so the counter runs from 0 to 12 and then restarts. The counter has no preset and cannot count down.

Top module: `twin_section_counter`

## Requirements
- R1: While `rst_n` is low, and after it is released, `q_out` is 0 until a count or a clear occurs.
- R2: The lower section is `q_out[0]`. It inverts on each falling edge of `tick_a`, on the third rising `clk` edge after that input falls. A rising edge of `tick_a` has no effect.
- R3: With `chain_en` low, the upper section is `q_out[3:1]` with `q_out[1]` as its LSB. It adds one on each falling edge of `tick_b`, with the same three-edge latency, wraps from 7 to 0, and does not depend on `tick_a`.
- R4: With `chain_en` high, the upper section adds one on the same `clk` edge at which `q_out[0]` goes from 1 to 0. `tick_b` is then ignored, and `q_out` counts 0 to 15 and wraps to 0.
- R5: When `clr_a` and `clr_b` are both high at a rising `clk` edge, `q_out` is 0 after that edge, even if a count is due on that edge. Either input high on its own has no effect.
- R6: With `mod13_en` high, any next value that has bits 3, 2 and 0 all set is replaced by 0. The chained count therefore runs 0 to 12 and returns to 0, and value 13 never appears on `q_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick_a | input | 1 | Count clock of the one-bit section (falling edge counts) |
| tick_b | input | 1 | Count clock of the three-bit section (falling edge counts) |
| clr_a | input | 1 | First input of the gated clear |
| clr_b | input | 1 | Second input of the gated clear |
| chain_en | input | 1 | 1: lower bit drives the upper section |
| mod13_en | input | 1 | 1: count decode feeds the gated clear (modulo 13) |
| q_out | output | 4 | Count value; bit 0 is the lower section |

## Verification
A count from either count input shows up on the third rising `clk` edge after the input falls. That is two synchronizer stages plus the count register. A clear, or a modulo restart, shows up on the first edge. The bench drives inputs on falling `clk` edges and keeps a behavioural model that delays each count input by three rising-edge samples. It compares `q_out` with this model at every falling edge. Directed checks are placed two and three edges after a falling input, which pins the latency at both sides.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // Synchronizer depth applied to each count input
    localparam int DEF_SYNC_STAGES = 2;

    // Per-section flags passed from a section to the top
    typedef struct packed {
        logic advance;
        logic wrap;
    } sect_flags_t;

    // True when every bit selected by mask is set in value
    function automatic logic all_set(input logic [15:0] value, input logic [15:0] mask);
        return (value & mask) == mask;
    endfunction

endpackage

// File: rtl/ctr_fall_detect.sv
module ctr_fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.sync = {det_q.sync[STAGES-2:0], raw_in};
        det_d.prev = det_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign fall_o = det_q.prev & ~det_q.sync[STAGES-1];
endmodule

// File: rtl/ctr_section.sv
module ctr_section #(
    parameter int W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             clr_i,
    output logic [W-1:0]     cnt_o,
    output logic [W-1:0]     nxt_o,
    output ctr_pkg::sect_flags_t flags_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } sec_t;

    sec_t sec_d, sec_q;
    logic [W-1:0] stepped;

    always_comb begin
        stepped         = adv_i ? sec_q.cnt + W'(1) : sec_q.cnt;
        sec_d           = sec_q;
        sec_d.cnt       = clr_i ? '0 : stepped;
        flags_o.advance = adv_i;
        flags_o.wrap    = adv_i & (&sec_q.cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else begin
            sec_q <= sec_d;
        end
    end

    assign cnt_o = sec_q.cnt;
    assign nxt_o = stepped;
endmodule

// File: rtl/twin_section_counter.sv
module twin_section_counter #(
    parameter int SYNC_STAGES = ctr_pkg::DEF_SYNC_STAGES,
    parameter int HIGH_W      = 3,
    parameter int TERM_MASK   = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_a,
    input  logic                 tick_b,
    input  logic                 clr_a,
    input  logic                 clr_b,
    input  logic                 chain_en,
    input  logic                 mod13_en,
    output logic [HIGH_W:0]      q_out
);
    localparam int Q_W = HIGH_W + 1;
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_vec;
    logic [N_IN-1:0] fall_vec;

    logic              lo_cnt, lo_nxt;
    logic [HIGH_W-1:0] hi_cnt, hi_nxt;
    ctr_pkg::sect_flags_t lo_flags, hi_flags;
    logic              hi_adv;
    logic              clear_all;
    logic [Q_W-1:0]    nxt_all;

    assign raw_vec = {tick_b, tick_a};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_det
        ctr_fall_detect #(.STAGES(SYNC_STAGES)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_in (raw_vec[gi]),
            .fall_o (fall_vec[gi])
        );
    end

    always_comb begin
        hi_adv    = chain_en ? lo_flags.wrap : fall_vec[1];
        nxt_all   = {hi_nxt, lo_nxt};
        clear_all = (clr_a & clr_b)
                  | (mod13_en & ctr_pkg::all_set(16'(nxt_all), 16'(TERM_MASK)));
    end

    ctr_section #(.W(1)) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (fall_vec[0]),
        .clr_i   (clear_all),
        .cnt_o   (lo_cnt),
        .nxt_o   (lo_nxt),
        .flags_o (lo_flags)
    );

    ctr_section #(.W(HIGH_W)) u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (hi_adv),
        .clr_i   (clear_all),
        .cnt_o   (hi_cnt),
        .nxt_o   (hi_nxt),
        .flags_o (hi_flags)
    );

    assign q_out = {hi_cnt, lo_cnt};

    logic unused_ok;
    assign unused_ok = &{1'b0, lo_flags.advance, hi_flags};
endmodule

// File: rtl/ctr_checker.sv
module ctr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_a,
    input logic       clr_b,
    input logic       chain_en,
    input logic       mod13_en,
    input logic       fall_a,
    input logic       fall_b,
    input logic [3:0] q_out
);
    always_comb begin
        if (!rst_n) begin
            assert_reset_zero_R1: assert (q_out == 4'd0);
        end
    end

    assert_low_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_a && !(clr_a && clr_b) && !mod13_en) |=> $stable(q_out[0]));

    assert_low_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_a && !(clr_a && clr_b) && !mod13_en) |=> (q_out[0] != $past(q_out[0])));

    assert_upper_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_en && !fall_b && !(clr_a && clr_b) && !mod13_en) |=> $stable(q_out[3:1]));

    assert_chain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_en && !fall_a && !(clr_a && clr_b) && !mod13_en) |=> $stable(q_out[3:1]));

    assert_gated_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && clr_b) |=> (q_out == 4'd0));

    assert_no_terminal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mod13_en |=> !(q_out[3] && q_out[2] && q_out[0]));
endmodule

bind twin_section_counter ctr_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_a    (clr_a),
    .clr_b    (clr_b),
    .chain_en (chain_en),
    .mod13_en (mod13_en),
    .fall_a   (fall_vec[0]),
    .fall_b   (fall_vec[1]),
    .q_out    (q_out)
);

// File: tb/twin_section_counter_test.sv
`timescale 1ns/1ps
module twin_section_counter_test;
    logic clk = 0;
    logic rst_n = 0;
    logic tick_a = 0, tick_b = 0, clr_a = 0, clr_b = 0, chain_en = 0, mod13_en = 0;
    logic [3:0] q_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string phase = "R1";

    // Reference model state
    int exp_q = 0;
    bit ha1, ha2, ha3, hb1, hb2, hb3;

    always #4 clk = ~clk;

    twin_section_counter uut (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .clr_a(clr_a), .clr_b(clr_b), .chain_en(chain_en),
        .mod13_en(mod13_en), .q_out(q_out)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q = 0;
            {ha1, ha2, ha3, hb1, hb2, hb3} = '0;
        end else begin
            bit fa, fb, adv_hi;
            int lo, hi, nv;
            fa = ha3 && !ha2;
            fb = hb3 && !hb2;
            lo = exp_q % 2;
            hi = exp_q / 2;
            adv_hi = chain_en ? (fa && lo == 1) : fb;
            if (fa) lo = 1 - lo;
            if (adv_hi) hi = (hi + 1) % 8;
            nv = hi * 2 + lo;
            if ((clr_a && clr_b) || (mod13_en && (nv & 13) == 13)) nv = 0;
            exp_q = nv;
            ha3 = ha2; ha2 = ha1; ha1 = tick_a;
            hb3 = hb2; hb2 = hb1; hb1 = tick_b;
        end
    end

    always @(negedge clk) begin
        cycles++;
        checks++;
        if (int'(q_out) != exp_q) begin
            failures++;
            $display("FAIL %s cycle %0d: q_out actual=%0d expected=%0d", phase, cycles, q_out, exp_q);
        end
        if (cycles > 50000) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_a(input int n);
        for (int i = 0; i < n; i++) begin
            tick_a = 1; idle(3);
            tick_a = 0; idle(4);
        end
    endtask

    task automatic pulse_b(input int n);
        for (int i = 0; i < n; i++) begin
            tick_b = 1; idle(3);
            tick_b = 0; idle(4);
        end
    endtask

    task automatic clear_now();
        clr_a = 1; clr_b = 1; idle(1);
        clr_a = 0; clr_b = 0; idle(1);
    endtask

    initial begin
        idle(3);
        chk("R1 reset held", int'(q_out), 0);
        rst_n = 1;
        idle(3);
        chk("R1 after release", int'(q_out), 0);

        // R2: latency and rising-edge immunity
        phase = "R2";
        tick_a = 1; idle(6);
        chk("R2 rising edge ignored", int'(q_out), 0);
        tick_a = 0; idle(2);
        chk("R2 not yet at second edge", int'(q_out), 0);
        idle(1);
        chk("R2 toggled at third edge", int'(q_out), 1);
        pulse_a(2);
        chk("R2 three falls", int'(q_out), 1);

        // R3: separate upper section
        phase = "R3";
        pulse_b(9);
        chk("R3 upper wraps 7 to 0", int'(q_out[3:1]), 1);
        chk("R3 lower untouched", int'(q_out[0]), 1);
        pulse_b(2);
        chk("R3 upper count", int'(q_out), 7);

        // R5: gated clear
        phase = "R5";
        clr_a = 1; idle(2); clr_a = 0;
        chk("R5 clr_a alone", int'(q_out), 7);
        clr_b = 1; idle(2); clr_b = 0;
        chk("R5 clr_b alone", int'(q_out), 7);
        tick_b = 1; idle(3); tick_b = 0;
        clr_a = 1; clr_b = 1; idle(5);
        chk("R5 clear beats count", int'(q_out), 0);
        clr_a = 0; clr_b = 0; idle(2);
        chk("R5 restart from zero", int'(q_out), 0);

        // R4: chained
        phase = "R4";
        chain_en = 1;
        pulse_a(5);
        chk("R4 chained five", int'(q_out), 5);
        pulse_b(3);
        chk("R4 tick_b ignored", int'(q_out), 5);
        pulse_a(11);
        chk("R4 wraps 15 to 0", int'(q_out), 0);
        pulse_a(8);
        chk("R4 carry into bit 3", int'(q_out), 8);
        clear_now();

        // R6: modulo 13
        phase = "R6";
        mod13_en = 1;
        pulse_a(12);
        chk("R6 reaches 12", int'(q_out), 12);
        pulse_a(1);
        chk("R6 12 returns to 0", int'(q_out), 0);
        pulse_a(15);
        chk("R6 second lap", int'(q_out), 2);

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule